// File: doc/BRIEF.md
# Triggered Capture Write Controller

This block is the recording side of an on-chip logic analyzer. Once armed, it stores one sample word of the probed signals in a circular capture memory on every clock. At the same time it watches a trigger line for a rising edge. The pre-trigger share of the window must already be filled before an edge is accepted. When the trigger is taken, the controller records a fixed number of further samples, then stops writing. So the trigger sample lands at 30 %, 50 % or 70 % of the record window, as configured.

The probe word reaches the memory through a register chain several stages long. Each write address and write enable travel through a matching chain, so every sample lands in the slot chosen in the cycle it was taken.

When the last write has landed, the block raises a one-cycle finish pulse and holds a done flag until it is armed again. It also reports the slot of the oldest valid sample, which is where readout starts. A simple registered read port gives access to the memory contents.

Top module: `capture_write_ctrl`

## Requirements
- R1: After reset, `finish_o` and `done_o` are low.
- R2: While capturing, the sample present on `probe_i` is written on every clock to the next slot. A capture that starts after arming uses slot 0 first. Each sample arrives at its own slot even though the data path lags by `LAT` cycles.
- R3: A trigger is a rising edge of `trig_i` between two consecutive clocks. A level that is already high when capture starts is not a trigger.
- R4: `split_i` sets the post-trigger share of the window: 0 gives 70 %, 1 gives 50 %, 2 gives 30 %, and 3 behaves as 1. The post count is depth × share / 100, rounded down. The pre count is depth minus the post count.
- R5: A rising edge is ignored until at least the pre count of samples has been taken since arming. An edge on exactly the sample after the pre count is accepted.
- R6: The trigger sample is the first of the post-count samples. After the last of them, no further writes occur, whatever `probe_i` does.
- R7: `finish_o` is high for exactly one cycle, after the last write. `done_o` rises with it and stays high until the next accepted `arm_i`, which clears it.
- R8: After finishing, further trigger edges produce no second finish pulse.
- R9: While done, `rd_start_o` gives the slot of the oldest sample. This is the count of samples taken, modulo the depth.
- R10: `arm_i` is ignored while a capture is in progress.
- R11: The record depth `depth_i` (4 to 2^ADDR_W) is latched at arming. Slot addresses wrap modulo that depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Start a capture with the present configuration |
| depth_i | input | ADDR_W+1 | Record depth in samples |
| split_i | input | 2 | Pre/post split selector |
| probe_i | input | PROBE_W | Probed signal word |
| trig_i | input | 1 | Trigger signal |
| rd_addr_i | input | ADDR_W | Capture memory read slot |
| finish_o | output | 1 | One-cycle end-of-capture pulse |
| done_o | output | 1 | Capture complete flag |
| rd_start_o | output | ADDR_W | Slot of the oldest sample |
| rd_data_o | output | PROBE_W | Read data, one cycle after the address |

## Verification
Two things can fall in the same cycle: the pre-count gate opening and a trigger edge arriving. The bench provokes this by placing the rising edge on exactly the sample that completes the pre count, and judges it by the window contents and the start slot. A second overlap is an arm pulse arriving in the middle of a capture, together with a different depth. Ignoring it is judged by the unchanged window geometry. Earlier edges, and a level held high across arming, are checked to leave the window where the later true edge puts it.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

    typedef enum logic [1:0] {
        SPLIT_PRE30 = 2'd0,
        SPLIT_EVEN  = 2'd1,
        SPLIT_PRE70 = 2'd2,
        SPLIT_SPARE = 2'd3
    } split_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_POST,
        ST_DRAIN,
        ST_DONE
    } cap_state_e;

    // post-trigger share of the window, in percent
    function automatic int unsigned post_share(input logic [1:0] sel);
        case (split_e'(sel))
            SPLIT_PRE30: return 70;
            SPLIT_PRE70: return 30;
            default:     return 50;
        endcase
    endfunction

    function automatic int unsigned post_len(input int unsigned depth, input logic [1:0] sel);
        return (depth * post_share(sel)) / 100;
    endfunction

endpackage

// File: rtl/cwc_trig_edge.sv
module cwc_trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic rise_o
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_i;
    end

    assign rise_o = trig_i & ~trig_q;
endmodule

// File: rtl/cwc_sequencer.sv
module cwc_sequencer
    import cwc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic [ADDR_W:0]   depth_i,
    input  logic [1:0]        split_i,
    input  logic              rise_i,
    output logic              issue_o,
    output logic [ADDR_W-1:0] slot_o,
    output logic              finish_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W:0]   depth_o
);
    localparam int CW = ADDR_W + 1;
    localparam int DW = (LAT > 1) ? $clog2(LAT) : 1;

    cap_state_e        state;
    logic [CW-1:0]     depth_q, pre_q, post_q, cnt, rem;
    logic [DW-1:0]     dcnt;
    logic [ADDR_W-1:0] wptr, wptr_nx, start_q;
    logic              finish_q, done_q;
    logic [CW-1:0]     post_cfg;

    assign post_cfg = CW'(post_len(int'(depth_i), split_i));
    assign wptr_nx  = (CW'(wptr) == depth_q - 1'b1) ? '0 : wptr + 1'b1;
    assign issue_o  = (state == ST_PRE) || (state == ST_POST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            depth_q  <= CW'(4);
            pre_q    <= '0;
            post_q   <= '0;
            cnt      <= '0;
            rem      <= '0;
            dcnt     <= '0;
            wptr     <= '0;
            start_q  <= '0;
            finish_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            finish_q <= 1'b0;
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (arm_i) begin
                        depth_q <= depth_i;
                        post_q  <= post_cfg;
                        pre_q   <= depth_i - post_cfg;
                        cnt     <= '0;
                        wptr    <= '0;
                        done_q  <= 1'b0;
                        state   <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    wptr <= wptr_nx;
                    if (cnt < pre_q) cnt <= cnt + 1'b1;
                    if (rise_i && (cnt >= pre_q)) begin
                        if (post_q == CW'(1)) begin
                            dcnt  <= '0;
                            state <= ST_DRAIN;
                        end else begin
                            rem   <= post_q - 1'b1;
                            state <= ST_POST;
                        end
                    end
                end
                ST_POST: begin
                    wptr <= wptr_nx;
                    if (rem == CW'(1)) begin
                        dcnt  <= '0;
                        state <= ST_DRAIN;
                    end else begin
                        rem <= rem - 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (dcnt == DW'(LAT - 1)) begin
                        state    <= ST_DONE;
                        finish_q <= 1'b1;
                        done_q   <= 1'b1;
                        start_q  <= wptr;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign slot_o   = wptr;
    assign finish_o = finish_q;
    assign done_o   = done_q;
    assign start_o  = start_q;
    assign depth_o  = depth_q;
endmodule

// File: rtl/cwc_align_pipe.sv
module cwc_align_pipe #(
    parameter int ADDR_W  = 5,
    parameter int PROBE_W = 8,
    parameter int LAT     = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [PROBE_W-1:0] data_i,
    output logic               en_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [PROBE_W-1:0] data_o
);
    typedef struct packed {
        logic               en;
        logic [ADDR_W-1:0]  addr;
        logic [PROBE_W-1:0] data;
    } stage_t;

    stage_t stg [LAT];

    for (genvar i = 0; i < LAT; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= '{en: en_i, addr: addr_i, data: data_i};
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign en_o   = stg[LAT-1].en;
    assign addr_o = stg[LAT-1].addr;
    assign data_o = stg[LAT-1].data;
endmodule

// File: rtl/cwc_ram.sv
module cwc_ram #(
    parameter int ADDR_W  = 5,
    parameter int PROBE_W = 8
) (
    input  logic               clk,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  waddr_i,
    input  logic [PROBE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]  raddr_i,
    output logic [PROBE_W-1:0] rdata_o
);
    localparam int SLOTS = 1 << ADDR_W;

    logic [PROBE_W-1:0] mem [SLOTS];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/capture_write_ctrl.sv
module capture_write_ctrl #(
    parameter int PROBE_W = 8,
    parameter int ADDR_W  = 5,
    parameter int LAT     = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm_i,
    input  logic [ADDR_W:0]    depth_i,
    input  logic [1:0]         split_i,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic               trig_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic               finish_o,
    output logic               done_o,
    output logic [ADDR_W-1:0]  rd_start_o,
    output logic [PROBE_W-1:0] rd_data_o
);
    logic               rise, issue, ram_we;
    logic [ADDR_W-1:0]  slot, ram_addr;
    logic [PROBE_W-1:0] ram_data;
    logic [ADDR_W:0]    depth_q;

    cwc_trig_edge u_edge (
        .clk(clk), .rst(rst), .trig_i(trig_i), .rise_o(rise)
    );

    cwc_sequencer #(.ADDR_W(ADDR_W), .LAT(LAT)) u_seq (
        .clk(clk), .rst(rst), .arm_i(arm_i), .depth_i(depth_i),
        .split_i(split_i), .rise_i(rise), .issue_o(issue), .slot_o(slot),
        .finish_o(finish_o), .done_o(done_o), .start_o(rd_start_o),
        .depth_o(depth_q)
    );

    cwc_align_pipe #(.ADDR_W(ADDR_W), .PROBE_W(PROBE_W), .LAT(LAT)) u_pipe (
        .clk(clk), .rst(rst), .en_i(issue), .addr_i(slot), .data_i(probe_i),
        .en_o(ram_we), .addr_o(ram_addr), .data_o(ram_data)
    );

    cwc_ram #(.ADDR_W(ADDR_W), .PROBE_W(PROBE_W)) u_ram (
        .clk(clk), .we_i(ram_we), .waddr_i(ram_addr), .wdata_i(ram_data),
        .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
    );
endmodule

// File: rtl/cwc_checker.sv
module cwc_checker #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              arm_i,
    input logic              finish_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] rd_start_o,
    input logic [ADDR_W:0]   depth_q,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr
);
    p_finish_single_r7: assert property (@(posedge clk) disable iff (rst)
        finish_o |=> !finish_o);

    p_finish_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        finish_o |-> done_o);

    p_done_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !arm_i) |=> done_o);

    p_no_refinish_r8: assert property (@(posedge clk) disable iff (rst)
        finish_o |-> !$past(done_o));

    p_no_write_done_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !ram_we);

    p_start_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(done_o)) |-> $stable(rd_start_o));

    p_slot_in_range_r11: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ({1'b0, ram_addr} < depth_q));
endmodule

bind capture_write_ctrl cwc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .arm_i(arm_i), .finish_o(finish_o),
    .done_o(done_o), .rd_start_o(rd_start_o), .depth_q(depth_q),
    .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/capture_write_ctrl_tb.sv
module capture_write_ctrl_tb;
    localparam int PW = 8;
    localparam int AW = 5;
    localparam int LT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm_i = 1'b0;
    logic [AW:0]   depth_i = '0;
    logic [1:0]    split_i = '0;
    logic [PW-1:0] probe_i = '0;
    logic          trig_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic          finish_o, done_o;
    logic [AW-1:0] rd_start_o;
    logic [PW-1:0] rd_data_o;

    int errors = 0;
    int checks = 0;
    int fin_cnt = 0;
    int cyc = 0;
    logic rd_vld = 1'b0;
    logic vld_d = 1'b0;
    logic [PW-1:0] exp_q[$];
    string tag_q[$];

    capture_write_ctrl #(.PROBE_W(PW), .ADDR_W(AW), .LAT(LT)) u_dut (
        .clk(clk), .rst(rst), .arm_i(arm_i), .depth_i(depth_i),
        .split_i(split_i), .probe_i(probe_i), .trig_i(trig_i),
        .rd_addr_i(rd_addr_i), .finish_o(finish_o), .done_o(done_o),
        .rd_start_o(rd_start_o), .rd_data_o(rd_data_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: read data arrives one clock after the address
    always @(posedge clk) vld_d <= rd_vld;
    always @(negedge clk) begin
        if (finish_o) fin_cnt++;
        if (vld_d && exp_q.size() > 0) begin
            logic [PW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rd_data_o == e, t, int'(rd_data_o), int'(e));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic int post_of(input int d, input int sp);
        int pct;
        pct = (sp == 0) ? 70 : (sp == 2) ? 30 : 50;
        return (d * pct) / 100;
    endfunction

    // d: depth, sp: split, tk: trigger sample index, early: ignored edge index,
    // hold: trigger level high across arming, glitch: index of a mid-capture arm
    task automatic run_case(input int d, input int sp, input int tk, input int early,
                            input bit hold, input int glitch, input int seed);
        int post, start, idx;
        post = post_of(d, sp);
        start = (tk + post) % d;
        fin_cnt = 0;
        @(negedge clk);
        depth_i = (AW+1)'(d); split_i = sp[1:0]; arm_i = 1'b1; trig_i = hold;
        @(negedge clk);
        arm_i = 1'b0;
        chk(done_o == 1'b0, "R7 done cleared by arm", int'(done_o), 0);
        idx = 0;
        while (!done_o && idx < 400) begin
            probe_i = PW'(seed + idx);
            if (hold) trig_i = (idx < tk - 1) ? 1'b1 : (idx == tk);
            else      trig_i = (idx == tk) || (idx == early);
            arm_i = (idx == glitch);
            if (idx == glitch) depth_i = (AW+1)'(16);
            @(negedge clk);
            idx++;
        end
        arm_i = 1'b0;
        // R6/R8: keep probing and toggling the trigger after finish
        for (int k = 0; k < 12; k++) begin
            probe_i = PW'(seed + 200 + k);
            trig_i = k[0];
            @(negedge clk);
        end
        trig_i = 1'b0;
        chk(fin_cnt == 1, "R7 R8 single finish pulse", fin_cnt, 1);
        chk(done_o == 1'b1, "R7 done held", int'(done_o), 1);
        chk(int'(rd_start_o) == start, "R9 oldest slot", int'(rd_start_o), start);
        // R2 R5 R6 R11: window contents, oldest first
        for (int j = 0; j < d; j++) begin
            rd_addr_i = AW'((start + j) % d);
            rd_vld = 1'b1;
            exp_q.push_back(PW'(seed + tk + post - d + j));
            tag_q.push_back($sformatf("R2 R5 R6 R11 slot %0d split %0d", (start + j) % d, sp));
            @(negedge clk);
        end
        rd_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads compared", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(finish_o == 1'b0, "R1 finish after reset", int'(finish_o), 0);
        chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        // R4 R5: even split, edge right at the pre-count boundary, earlier edge ignored
        run_case(20, 1, 10, 4, 1'b0, -1, 7);
        // R4: 30/70, full depth wrap
        run_case(32, 0, 15, -1, 1'b0, -1, 90);
        // R3 R10: level high across arming, mid-capture arm with another depth
        run_case(10, 2, 20, -1, 1'b1, 3, 33);
        // R4: spare code behaves as the even split, odd depth
        run_case(7, 3, 9, 2, 1'b0, -1, 150);
        // R5: pre count of 3 reached exactly at the trigger
        run_case(10, 0, 3, 1, 1'b0, -1, 60);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule